// File: doc/BRIEF.md
# Recursive Optical-Black Digital Clamp

This block removes the dark offset from a stream of 10-bit image sensor samples. Every line opens with a run of shielded (optical-black) samples. The clamp sums a fixed, power-of-two number of them and takes their mean. It then folds that mean into a running black estimate with a first-order recursive filter across lines. The result is a black level that stays steady from one line to the next, instead of following the noise of any single line.

Each sample that arrives is corrected by the estimate that is in force at that moment. The correction subtracts the estimate from the sample and clips the result at zero. The smoothing weight `k_coef` is an unsigned fraction of 256, and it sets how much of the previous estimate is kept. A larger `k_coef` means slower, heavier smoothing.

Control is a four-state machine:
- `ST_IDLE`: no line has started since reset.
- `ST_GATHER`: black samples are being summed.
- `ST_MIX`: a single cycle in which the full window's mean is loaded into the estimate or blended with it.
- `ST_PASS`: the rest of the line, or a window that was abandoned.

The transitions are:
- A line start moves any state to `ST_GATHER`, or straight to `ST_MIX` or `ST_PASS` when the starting sample is the last black sample of the window or is not a black sample.
- `ST_GATHER` stays in `ST_GATHER` on each black sample until the window is full, then goes to `ST_MIX`.
- A non-black sample sends `ST_GATHER` to `ST_PASS`.
- `ST_MIX` always leaves after one cycle.
- `ST_PASS` waits for the next line start.

Top module: `black_clamp_top`

## Requirements
- R1: After reset `out_valid` is 0 and the black estimate is 0, so samples pass through unchanged until the first full window has been taken.
- R2: Every sample accepted with `in_valid`=1 appears on `out_pix` exactly two clock cycles later, with `out_valid`=1. `out_valid` is 0 in every other cycle.
- R3: `out_pix` equals the input sample minus the estimate in force, treated as unsigned 10-bit values, and is 0 when the estimate is greater than or equal to the sample.
- R4: A sample with `in_sol`=1 starts a line. The first 16 samples of that line with `in_ob`=1, counting from the line start, form the window, and the window mean is their sum shifted right by 4.
- R5: The first full window after reset loads its mean directly into the estimate, whatever the value of `k_coef`.
- R6: Each later full window sets the estimate to prev + floor((mean − prev)·(256 − k)/256), where k is `k_coef`. So k=0 gives the mean, and k=255 moves the estimate by floor((mean − prev)/256).
- R7: The new estimate applies to the sample that arrives in the cycle right after the last window sample, and to every sample after it. The window samples themselves use the older estimate.
- R8: If a line's window is cut short, the estimate is left unchanged. A window is cut short when a sample with `in_ob`=0 arrives, or when a new line starts, before 16 black samples have been taken.
- R9: Samples with `in_ob`=1 are not counted once 16 have been taken in a line, and are not counted after a sample with `in_ob`=0 has ended the window.
- R10: In cycles with `in_valid`=0, `in_pix`, `in_sol` and `in_ob` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample qualifier |
| in_pix | input | 10 | Input sample |
| in_sol | input | 1 | Sample is the first of a line |
| in_ob | input | 1 | Sample is an optical-black sample |
| k_coef | input | 8 | Recursion weight on the previous estimate, k/256 |
| out_valid | output | 1 | Output sample qualifier |
| out_pix | output | 10 | Clamped output sample |

## Verification
The recursion is exercised with k set to half scale, zero, full scale and quarter scale. These settings separate a plain per-line mean from a true blend, and they exercise the floor rounding when the mean falls below the estimate.

Some lines carry windows that are too short, and some carry more black samples than the window holds. These lines show whether the update is gated by the 16-sample count rather than by the flag alone.

Other stimulus inserts idle cycles carrying stray flags inside a window. It also starts a new line in the very cycle after a window completes. These cases show that the blend cycle and the sum reset do not interfere, and that the new estimate reaches the first sample that follows the window.

// File: rtl/blk_clamp_pkg.sv
package blk_clamp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GATHER = 2'd1,
        ST_MIX    = 2'd2,
        ST_PASS   = 2'd3
    } clamp_state_e;

endpackage

// File: rtl/clamp_ob_ctrl.sv
module clamp_ob_ctrl
    import blk_clamp_pkg::*;
#(
    parameter int PIX_W   = 10,
    parameter int OB_LOG2 = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_pix,
    input  logic             in_sol,
    input  logic             in_ob,
    output logic             upd,
    output logic [PIX_W-1:0] avg
);

    localparam int OB_LEN = 1 << OB_LOG2;
    localparam int CNT_W  = OB_LOG2 + 1;
    localparam int SUM_W  = PIX_W + OB_LOG2;

    clamp_state_e state, nxt;
    logic [CNT_W-1:0] cnt, base_cnt;
    logic [SUM_W-1:0] sum, base_sum;
    logic start, gathering, take, last;
    clamp_state_e gather_next;

    always_comb begin
        start     = in_valid && in_sol;
        gathering = start || (state == ST_GATHER);
        base_cnt  = start ? '0 : cnt;
        base_sum  = start ? '0 : sum;
        take      = in_valid && gathering && in_ob;
        last      = take && (base_cnt == CNT_W'(OB_LEN - 1));
        if (last)
            gather_next = ST_MIX;
        else if (take)
            gather_next = ST_GATHER;
        else
            gather_next = ST_PASS;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   nxt = start ? gather_next : ST_IDLE;
            ST_GATHER: nxt = in_valid ? gather_next : ST_GATHER;
            ST_MIX:    nxt = start ? gather_next : ST_PASS;
            ST_PASS:   nxt = start ? gather_next : ST_PASS;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            sum <= '0;
        end else if (take) begin
            cnt <= base_cnt + CNT_W'(1);
            sum <= base_sum + SUM_W'(in_pix);
        end else if (start) begin
            cnt <= '0;
            sum <= '0;
        end
    end

    always_comb begin
        upd = (state == ST_MIX);
        avg = sum[SUM_W-1:OB_LOG2];
    end

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(OB_LEN)); // R9
    AST_MIX_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MIX) |-> (cnt == CNT_W'(OB_LEN))); // R8
    AST_MIX_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_MIX) && !in_valid) |=> (state == ST_PASS)); // R7
    AST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && (state == ST_GATHER)) |=> ($stable(cnt) && $stable(sum))); // R10

endmodule

// File: rtl/clamp_est_blend.sv
module clamp_est_blend #(
    parameter int PIX_W = 10,
    parameter int K_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic [PIX_W-1:0] avg,
    input  logic [K_W-1:0]   k_coef,
    output logic [PIX_W-1:0] est
);

    localparam int PROD_W = PIX_W + K_W + 3;

    logic                     seeded;
    logic signed [PIX_W:0]    diff;
    logic signed [K_W+1:0]    wgt;
    logic signed [PROD_W-1:0] prod, shf, total;
    logic        [PIX_W-1:0]  blended;

    always_comb begin
        diff    = $signed({1'b0, avg}) - $signed({1'b0, est});
        wgt     = $signed((K_W+2)'(1 << K_W)) - $signed({2'b00, k_coef});
        prod    = PROD_W'(diff) * PROD_W'(wgt);
        shf     = prod >>> K_W;
        total   = shf + $signed(PROD_W'(est));
        blended = total[PIX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            est    <= '0;
            seeded <= 1'b0;
        end else if (upd) begin
            est    <= seeded ? blended : avg;
            seeded <= 1'b1;
        end
    end

    AST_FIRST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !seeded) |=> (est == $past(avg))); // R5
    AST_BLEND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && seeded) |=> ((est >= $past(avg) || est >= $past(est)) &&
                             (est <= $past(avg) || est <= $past(est)))); // R6
    AST_EST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(est)); // R8

endmodule

// File: rtl/clamp_pix_sub.sv
module clamp_pix_sub #(
    parameter int PIX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_pix,
    input  logic [PIX_W-1:0] est,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_pix
);

    logic             v1;
    logic [PIX_W-1:0] p1;
    logic [PIX_W:0]   delta;

    always_comb delta = {1'b0, p1} - {1'b0, est};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1        <= 1'b0;
            p1        <= '0;
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            v1        <= in_valid;
            p1        <= in_valid ? in_pix : p1;
            out_valid <= v1;
            if (v1)
                out_pix <= delta[PIX_W] ? '0 : delta[PIX_W-1:0];
        end
    end

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid, 2)); // R2
    AST_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (v1 && (p1 <= est)) |=> (out_valid && out_pix == '0)); // R3

endmodule

// File: rtl/black_clamp_top.sv
module black_clamp_top #(
    parameter int PIX_W   = 10,
    parameter int OB_LOG2 = 4,
    parameter int K_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_pix,
    input  logic             in_sol,
    input  logic             in_ob,
    input  logic [K_W-1:0]   k_coef,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_pix
);

    logic             upd;
    logic [PIX_W-1:0] avg;
    logic [PIX_W-1:0] est;

    clamp_ob_ctrl #(.PIX_W(PIX_W), .OB_LOG2(OB_LOG2)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_pix   (in_pix),
        .in_sol   (in_sol),
        .in_ob    (in_ob),
        .upd      (upd),
        .avg      (avg)
    );

    clamp_est_blend #(.PIX_W(PIX_W), .K_W(K_W)) blend_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd    (upd),
        .avg    (avg),
        .k_coef (k_coef),
        .est    (est)
    );

    clamp_pix_sub #(.PIX_W(PIX_W)) sub_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_pix    (in_pix),
        .est       (est),
        .out_valid (out_valid),
        .out_pix   (out_pix)
    );

endmodule

// File: tb/black_clamp_top_tb_top.sv
module black_clamp_top_tb_top;

    localparam int OB_LEN = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [9:0] in_pix = '0;
    logic       in_sol = 1'b0;
    logic       in_ob = 1'b0;
    logic [7:0] k_coef = 8'd0;
    logic       out_valid;
    logic [9:0] out_pix;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    int    exp_q[$];
    string tag_q[$];

    // bench model of the black estimate
    int m_est    = 0;
    bit m_seeded = 0;
    bit m_inwin  = 0;
    int m_cnt    = 0;
    int m_sum    = 0;

    logic [1:0] vh;

    always #5 clk = ~clk;

    black_clamp_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_pix    (in_pix),
        .in_sol    (in_sol),
        .in_ob     (in_ob),
        .k_coef    (k_coef),
        .out_valid (out_valid),
        .out_pix   (out_pix)
    );

    function automatic int blend_ref(int prev, int cur, int k);
        int p;
        p = (cur - prev) * (256 - k);
        return prev + (p >>> 8);
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(bit v, int pix, bit sol, bit ob, string tag);
        int e;
        @(negedge clk);
        in_valid = v;
        in_pix   = 10'(pix);
        in_sol   = sol;
        in_ob    = ob;
        if (v) begin
            e = pix - m_est;
            if (e < 0) e = 0;
            exp_q.push_back(e);
            tag_q.push_back(tag);
            if (sol) begin
                m_inwin = 1; m_cnt = 0; m_sum = 0;
            end
            if (m_inwin) begin
                if (ob) begin
                    m_sum += pix;
                    m_cnt++;
                    if (m_cnt == OB_LEN) begin
                        m_est    = m_seeded ? blend_ref(m_est, m_sum >> 4, int'(k_coef)) : (m_sum >> 4);
                        m_seeded = 1;
                        m_inwin  = 0;
                    end
                end else begin
                    m_inwin = 0;
                end
            end
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(0, 1023, 1, 1, "R10");
    endtask

    // one line: n_ob black samples around ob_base, then n_act active samples
    task automatic line(int ob_base, int n_ob, int n_act, int act_base,
                        string ob_tag, string act_tag, bit gaps);
        for (int i = 0; i < n_ob; i++) begin
            drive(1, ob_base + (i % 4), (i == 0), 1, ob_tag);
            if (gaps) drive(0, 999, 1, 1, "R10");
        end
        for (int i = 0; i < n_act; i++) begin
            drive(1, (act_base + i * 45) % 1024, (n_ob == 0 && i == 0), 0,
                  (i == 0) ? "R7" : act_tag);
            if (gaps) drive(0, 5, 1, 1, "R10");
        end
    endtask

    // monitor: scoreboard compare and valid latency
    always @(posedge clk) begin
        if (!rst_n) vh <= 2'b00;
        else        vh <= {vh[0], in_valid};
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            check(out_valid == 1'b0, "R1", int'(out_valid), 0);
        end else if (!done) begin
            check(out_valid == vh[1], "R2", int'(out_valid), int'(vh[1]));
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(0, "R2", int'(out_pix), -1);
                end else begin
                    int    e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(int'(out_pix) == e, t, int'(out_pix), e);
                end
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: before any window the estimate is zero
        k_coef = 8'd128;
        drive(1, 77, 0, 0, "R1");
        drive(1, 5, 0, 1, "R1");
        // first full window loads directly (avg 61), active pixel 40 clips (R3)
        line(60, OB_LEN, 6, 40, "R1", "R5", 0);
        // blend with k=128: 61 + ((101-61)*128>>8) = 81
        line(100, OB_LEN, 5, 70, "R3", "R6", 0);
        // k=0: estimate equals the mean (201)
        k_coef = 8'd0;
        line(200, OB_LEN, 5, 150, "R6", "R4", 0);
        // k=255, mean below estimate: floor rounding gives 200
        k_coef = 8'd255;
        line(20, OB_LEN, 5, 199, "R6", "R6", 0);
        // short window: no update
        k_coef = 8'd128;
        line(500, 5, 5, 180, "R8", "R8", 0);
        // new line interrupts a window: no update
        line(600, 3, 0, 0, "R8", "R8", 0);
        line(20, 4, 3, 190, "R8", "R8", 0);
        // extra black samples beyond the window are ignored
        for (int i = 0; i < OB_LEN; i++) drive(1, 300 + (i % 4), (i == 0), 1, "R9");
        for (int i = 0; i < 4; i++) drive(1, 1000, 0, 1, "R9");
        drive(1, 260, 0, 0, "R9");
        drive(1, 1000, 0, 1, "R9");
        drive(1, 249, 0, 0, "R9");
        // idle cycles with stray flags inside window and line
        k_coef = 8'd64;
        line(400, OB_LEN, 4, 300, "R10", "R10", 1);
        // new line starts right after the window ends, then a line with no actives
        line(120, OB_LEN, 0, 0, "R7", "R7", 0);
        line(900, OB_LEN, 3, 350, "R7", "R7", 0);
        drive(1, 1023, 1, 0, "R8");
        drive(1, 512, 0, 0, "R8");
        idle(6);
        repeat (4) @(negedge clk);
        done = 1;
        check(exp_q.size() == 0, "R2", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule